// File: doc/BRIEF.md
# Power Swing Classifier

This block decides what a moving impedance locus means for a protected line. It watches two zone flags, sampled on a tick enable: one says the locus is inside an outer zone, the other says it is inside a nested inner zone. When the locus first crosses into the outer zone, two delay counts start. The block then waits to see whether the locus reaches the inner zone, and when. The result is one of three outcomes:

- **Slow swing (block).** The block delay runs out before the locus reaches the inner zone. The swing-block flag is raised.
- **Unstable swing (trip).** The locus reaches the inner zone after the trip delay has run out but before the block delay has. The block trips, either at entry to the inner zone or after the locus leaves it again, as chosen by a mode input.
- **Fault.** The locus reaches the inner zone before the trip delay has run out. Nothing is raised.

Delays are counted in ticks. The trip count must trail the block count by at least half a power cycle, given as a tick count parameter. A combinational check flags any setting that breaks this margin and holds the classifier quiet while the setting stays wrong.

Top module: `swing_classifier`

## Requirements
- R1: Time is counted only on cycles with `tick` high. The tick on which the locus goes from outside to inside the outer zone is count 0, and each later tick adds one. Cycles without `tick` change nothing.
- R2: `swing_block` rises after the tick whose count equals `block_dly` if the locus is still in the outer zone. It wins even if the inner flag is set on that same tick.
- R3: With `exit_mode`=0, `trip_entry` rises after the tick on which the inner flag is first seen. This requires that tick's count to be at least `trip_dly` and below `block_dly`.
- R4: With `exit_mode`=1, the same qualifying entry causes no output by itself. `trip_exit` rises after the first later tick with the inner flag clear.
- R5: `trip_any` equals `trip_entry` OR `trip_exit` in every cycle.
- R6: `set_err` is high exactly when `trip_dly` + `HALF_TICKS` > `block_dly`. Equality is accepted.
- R7: While `set_err` is high, `swing_block`, `trip_entry`, `trip_exit` and `trip_any` are low. The classifier returns to idle.
- R8: If the inner flag is seen on a tick whose count is below `trip_dly`, the event is a fault. No output rises until the locus has left the outer zone.
- R9: Once raised, block and trip outputs stay high until a tick finds the locus outside the outer zone. The outputs are low after that tick, and the next entry starts again from count 0.
- R10: An inner flag that is set while the outer flag is clear counts as inside both zones.
- R11: Synchronous active-high `rst` returns the block to idle with all outputs low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample enable for zone flags and counting |
| in_outer | input | 1 | Locus inside outer zone |
| in_inner | input | 1 | Locus inside inner zone |
| exit_mode | input | 1 | 0: trip on inner entry, 1: trip on inner exit |
| trip_dly | input | CNT_W | Trip delay in ticks |
| block_dly | input | CNT_W | Block delay in ticks |
| swing_block | output | 1 | Swing blocking declared |
| trip_entry | output | 1 | Trip declared on inner entry |
| trip_exit | output | 1 | Trip declared on inner exit |
| trip_any | output | 1 | OR of both trip outputs |
| set_err | output | 1 | Delay settings violate the half-cycle margin |

## Verification
The bench targets the single-tick boundaries:

- **Inner entry exactly at `trip_dly`.** An off-by-one design would call a real swing a fault.
- **Inner entry on the tick where the block delay expires.** A design with the wrong priority would trip instead of block.
- **`trip_dly` + `HALF_TICKS` equal to `block_dly`.** A design that misreads the margin would reject this legal setting.

It also makes the settings illegal while an output is latched, which a design without gating would keep asserted. It drives an inner flag with no outer flag, which a literal design would ignore. It leaves gaps between ticks, which a design counting clocks would expire too early.

// File: rtl/swing_classifier.sv
module swing_classifier #(
  parameter int CNT_W      = 8,
  parameter int HALF_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             in_outer,
  input  logic             in_inner,
  input  logic             exit_mode,
  input  logic [CNT_W-1:0] trip_dly,
  input  logic [CNT_W-1:0] block_dly,
  output logic             swing_block,
  output logic             trip_entry,
  output logic             trip_exit,
  output logic             trip_any,
  output logic             set_err
);
  localparam logic [CNT_W:0] HALF_W = HALF_TICKS[CNT_W:0];

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_INNER, S_BLOCK, S_TRIP_IN, S_TRIP_OUT, S_FAULT} st_t;

  st_t            st, st_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;
  logic           outer_eff;
  logic [CNT_W:0] elapsed;

  assign outer_eff = in_outer | in_inner;
  assign elapsed   = (st == S_IDLE) ? '0 : {1'b0, cnt} + 1'b1;
  assign set_err   = ({1'b0, trip_dly} + HALF_W) > {1'b0, block_dly};

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (tick) begin
      unique case (st)
        S_IDLE, S_RUN: begin
          if (!outer_eff) begin
            st_nx  = S_IDLE;
            cnt_nx = '0;
          end else if (elapsed >= {1'b0, block_dly}) begin
            st_nx = S_BLOCK;
          end else if (in_inner) begin
            if (elapsed < {1'b0, trip_dly}) st_nx = S_FAULT;
            else if (exit_mode)             st_nx = S_INNER;
            else                            st_nx = S_TRIP_IN;
          end else begin
            st_nx  = S_RUN;
            cnt_nx = elapsed[CNT_W-1:0];
          end
        end
        S_INNER: if (!in_inner) st_nx = S_TRIP_OUT;
        default: begin
          if (!outer_eff) begin
            st_nx  = S_IDLE;
            cnt_nx = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || set_err) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= cnt_nx;
    end
  end

  assign swing_block = (st == S_BLOCK)    && !set_err;
  assign trip_entry  = (st == S_TRIP_IN)  && !set_err;
  assign trip_exit   = (st == S_TRIP_OUT) && !set_err;
  assign trip_any    = trip_entry | trip_exit;

  p_reset_r11: assert property (@(posedge clk) rst |=> (!swing_block && !trip_any));

  p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({swing_block, trip_entry, trip_exit}));

  p_block_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_BLOCK && !tick && !set_err) |=> (st == S_BLOCK));

  p_clear_on_leave_r9: assert property (@(posedge clk) disable iff (rst)
    ((st == S_BLOCK || st == S_TRIP_IN || st == S_TRIP_OUT || st == S_FAULT)
      && tick && !outer_eff && !set_err) |=> (st == S_IDLE));

  p_entry_trip_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_entry) |-> $past(tick && in_inner && !exit_mode));

  p_exit_trip_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_exit) |-> $past(st == S_INNER && tick && !in_inner));

  p_err_idle_r7: assert property (@(posedge clk) disable iff (rst)
    set_err |=> (st == S_IDLE));
endmodule

// File: tb/swing_classifier_bench.sv
module swing_classifier_bench;
  localparam int CNT_W = 8;
  localparam int HALF  = 4;

  logic clk = 0;
  logic rst = 1, tick = 0, in_outer = 0, in_inner = 0, exit_mode = 0;
  logic [CNT_W-1:0] trip_dly = 3, block_dly = 8;
  logic swing_block, trip_entry, trip_exit, trip_any, set_err;

  int n_cmp = 0, n_bad = 0;
  int m_st = 0, m_n = 0;   // 0 idle 1 run 2 inner 3 block 4 trip-in 5 trip-out 6 fault

  always #4 clk = ~clk;

  swing_classifier #(.CNT_W(CNT_W), .HALF_TICKS(HALF)) u_swing_classifier (
    .clk(clk), .rst(rst), .tick(tick), .in_outer(in_outer), .in_inner(in_inner),
    .exit_mode(exit_mode), .trip_dly(trip_dly), .block_dly(block_dly),
    .swing_block(swing_block), .trip_entry(trip_entry), .trip_exit(trip_exit),
    .trip_any(trip_any), .set_err(set_err));

  function automatic bit exp_err();
    return (int'(trip_dly) + HALF) > int'(block_dly);
  endfunction

  function automatic logic [4:0] exp_out();
    bit e = exp_err();
    bit b = (m_st == 3) && !e, ti = (m_st == 4) && !e, to = (m_st == 5) && !e;
    return {b, ti, to, ti | to, e};
  endfunction

  task automatic model_update();
    bit ou;
    int n;
    ou = in_outer | in_inner;
    if (rst || exp_err()) begin m_st = 0; m_n = 0; end
    else if (tick) begin
      case (m_st)
        0, 1: begin
          n = (m_st == 0) ? 0 : m_n + 1;
          if (!ou) begin m_st = 0; m_n = 0; end
          else if (n >= int'(block_dly)) m_st = 3;
          else if (in_inner) m_st = (n < int'(trip_dly)) ? 6 : (exit_mode ? 2 : 4);
          else begin m_st = 1; m_n = n; end
        end
        2: if (!in_inner) m_st = 5;
        default: if (!ou) begin m_st = 0; m_n = 0; end
      endcase
    end
  endtask

  task automatic check(string tag);
    logic [4:0] act, exp;
    act = {swing_block, trip_entry, trip_exit, trip_any, set_err};
    exp = exp_out();
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {blk,tin,tout,any,err} actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit tk, bit o, bit i, string tag);
    @(negedge clk);
    tick = tk; in_outer = o; in_inner = i;
    model_update();
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic walk(int n_out, int n_in, int n_after, bit inner_only, bit gaps, string tag);
    step(1, 0, 0, tag);
    for (int k = 0; k < n_out; k++) begin
      if (gaps) step(0, 1, 0, tag);
      step(1, 1, 0, tag);
    end
    for (int k = 0; k < n_in; k++) begin
      if (gaps) step(0, !inner_only, 1, tag);
      step(1, !inner_only, 1, tag);
    end
    for (int k = 0; k < n_after; k++) step(1, 1, 0, tag);
    step(1, 0, 0, tag);
    step(1, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int t, b, no, ni, na;
    void'($urandom(32'h5eed_0421));
    rst = 1;
    step(0, 0, 0, "R11 reset");
    step(1, 1, 0, "R11 reset");
    rst = 0;
    // R3: entry exactly at count == trip_dly
    trip_dly = 3; block_dly = 8; exit_mode = 0;
    walk(3, 2, 1, 0, 0, "R3 entry trip");
    // R8: entry one tick early is a fault
    walk(2, 2, 1, 0, 0, "R8 fault");
    // R4 / R5: trip on exit
    exit_mode = 1;
    walk(4, 3, 3, 0, 0, "R4 R5 exit trip");
    // R2 / R9: block and latch
    walk(12, 0, 0, 0, 0, "R2 R9 block latch");
    // R2: inner seen on the block-expiry tick, block wins
    walk(8, 2, 0, 0, 0, "R2 block priority");
    // R1: idle cycles between ticks do not count
    exit_mode = 0;
    walk(3, 1, 2, 0, 1, "R1 tick gating");
    walk(2, 1, 2, 0, 1, "R1 tick gating fault");
    // R10: inner flag without outer flag
    trip_dly = 0; block_dly = 6;
    walk(0, 3, 0, 1, 0, "R10 inner only");
    // R6: margin equality accepted, one short rejected
    trip_dly = 4; block_dly = 8;
    step(0, 0, 0, "R6 margin equal ok");
    block_dly = 7;
    step(0, 0, 0, "R6 margin short err");
    // R7: outputs quiet under bad settings, including while latched
    walk(10, 2, 0, 0, 0, "R7 err quiet");
    block_dly = 8;
    step(1, 1, 0, "R7 setup");
    for (int k = 0; k < 9; k++) step(1, 1, 0, "R7 setup");
    block_dly = 2;
    step(0, 1, 0, "R7 err while latched");
    block_dly = 8;
    step(0, 1, 0, "R7 recovered idle");
    // R11: reset while latched
    for (int k = 0; k < 10; k++) step(1, 1, 0, "R11 setup");
    rst = 1;
    step(0, 1, 0, "R11 reset latched");
    rst = 0;
    walk(0, 0, 0, 0, 0, "R11 after");
    // Random swings (R1 R2 R3 R4 R8 R9)
    for (int e = 0; e < 400; e++) begin
      t = $urandom_range(0, 6);
      b = t + HALF + $urandom_range(0, 5) - (($urandom_range(0, 9) == 0) ? 2 : 0);
      trip_dly = t[CNT_W-1:0]; block_dly = b[CNT_W-1:0];
      exit_mode = $urandom_range(0, 1);
      no = $urandom_range(0, 14); ni = $urandom_range(0, 4); na = $urandom_range(0, 3);
      step(1, 0, 0, "random");
      for (int k = 0; k < no; k++) step($urandom_range(0, 3) != 0, 1, 0, "random");
      for (int k = 0; k < ni; k++) step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, 1, "random");
      for (int k = 0; k < na; k++) step($urandom_range(0, 3) != 0, 1, 0, "random");
      step(1, 0, 0, "random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule